// File: doc/BRIEF.md
# Invertible-Operand Add/NAND ALU with Result Flags

This block is a purely combinational arithmetic-logic unit. Two operands of a parameterised width pass through optional bitwise inversion. They are then combined by one of two core functions, a two's-complement sum or a bitwise NAND. The core result may also be inverted before it leaves the block. A four-bit control word sets each of these choices with one bit per choice. Every operation the block offers comes from combining these inversions around the single core.

Common operations map onto fixed control codes. The code 0000 adds the operands. The code 1001 subtracts the second operand from the first, because the inverse of (not A plus B) equals A minus B. The code 0011 gives AND, and the code 1110 gives OR. A negative flag and a zero flag are derived from the final result, so a downstream sequencer can branch on the outcome.

The block has no state and no clock. Its output and flags follow its inputs within the same cycle. The width parameter is meant for 4-bit and 16-bit instances. A second parameter chooses between a behavioural adder and an explicit ripple-carry chain.

Top module: `inv_alu`

## Requirements
- R1: When ctl[3] is 1, operand `a` is replaced by its bitwise complement before the core function. When it is 0, `a` passes unchanged.
- R2: When ctl[2] is 1, operand `b` is replaced by its bitwise complement before the core function. When it is 0, `b` passes unchanged.
- R3: When ctl[1] is 0, the core result is the sum of the two conditioned operands modulo 2^WIDTH. The carry-in is 0 and the carry out of the top bit is dropped.
- R4: When ctl[1] is 1, the core result is the bitwise NAND of the two conditioned operands.
- R5: When ctl[0] is 1, output `y` is the bitwise complement of the core result. Otherwise `y` equals the core result.
- R6: Output `neg` equals bit WIDTH-1 of `y`.
- R7: Output `zero` is 1 exactly when every bit of `y` is 0.
- R8: The block is combinational. `y`, `neg` and `zero` reflect the inputs presented in the same cycle, and earlier inputs have no effect.
- R9: The same behaviour holds for a 16-bit instance as for a 4-bit one.
- R10: Code 1001 yields a minus b modulo 2^WIDTH. Code 0011 yields a AND b. Code 1110 yields a OR b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ctl | input | 4 | Control word: [3] invert a, [2] invert b, [1] NAND instead of sum, [0] invert result |
| y | output | WIDTH | Final result |
| neg | output | 1 | Most significant bit of the result |
| zero | output | 1 | Result is all zeros |

## Verification
The assertions assume that `a`, `b` and `ctl` hold only known 0/1 values whenever they are evaluated. They also assume that the inputs change as a group, so that the outputs are judged on settled values rather than on a partly updated operand set. The stimulus changes all inputs together, shortly after a clock edge. It applies only defined values: an exhaustive sweep of every code and operand pair at width 4, and pseudo-random plus corner operands at width 16. Results are judged half a cycle later.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;

   localparam int CTL_W     = 4;
   localparam int BIT_INV_A = 3;
   localparam int BIT_INV_B = 2;
   localparam int BIT_FN    = 1;
   localparam int BIT_INV_Y = 0;

   typedef enum logic {
      CORE_SUM  = 1'b0,
      CORE_NAND = 1'b1
   } core_fn_e;

endpackage

// File: rtl/alu_cond_inv.sv
module alu_cond_inv #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] d,
   input  logic             flip,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("alu_cond_inv: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign q[i] = d[i] ^ flip;
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import inv_alu_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] z,
   input  core_fn_e         fn,
   output logic [WIDTH-1:0] r
);

   logic [WIDTH-1:0] sum;
   logic [WIDTH-1:0] nand_v;

   assign nand_v = ~(x & z);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_core: WIDTH must be at least 2");
      end

      if (RIPPLE) begin : g_ripple
         logic [WIDTH-1:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            assign sum[i] = x[i] ^ z[i] ^ cy[i];
            if (i < WIDTH - 1) begin : g_carry
               assign cy[i+1] = (x[i] & z[i]) | (cy[i] & (x[i] ^ z[i]));
            end
         end
      end else begin : g_behav
         assign sum = x + z;
      end
   endgenerate

   always_comb begin
      unique case (fn)
         CORE_SUM:  r = sum;
         CORE_NAND: r = nand_v;
         default:   r = sum;
      endcase
   end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] r,
   output logic             neg,
   output logic             zero
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("alu_flags: WIDTH must be at least 1");
      end
   endgenerate

   assign neg  = r[WIDTH-1];
   assign zero = ~(|r);

endmodule

// File: rtl/inv_alu.sv
module inv_alu
   import inv_alu_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [CTL_W-1:0] ctl,
   output logic [WIDTH-1:0] y,
   output logic             neg,
   output logic             zero
);

   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("inv_alu: WIDTH must lie in 2..64");
      end
   endgenerate

   logic [WIDTH-1:0] a_c;
   logic [WIDTH-1:0] b_c;
   logic [WIDTH-1:0] core_r;
   core_fn_e         fn;

   assign fn = core_fn_e'(ctl[BIT_FN]);

   alu_cond_inv #(.WIDTH(WIDTH)) u_inv_a (
      .d(a), .flip(ctl[BIT_INV_A]), .q(a_c)
   );

   alu_cond_inv #(.WIDTH(WIDTH)) u_inv_b (
      .d(b), .flip(ctl[BIT_INV_B]), .q(b_c)
   );

   alu_core #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_core (
      .x(a_c), .z(b_c), .fn(fn), .r(core_r)
   );

   alu_cond_inv #(.WIDTH(WIDTH)) u_inv_y (
      .d(core_r), .flip(ctl[BIT_INV_Y]), .q(y)
   );

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .r(y), .neg(neg), .zero(zero)
   );

   // Port-level checks on settled combinational values
   always_comb begin
      if (ctl == 4'b0000) begin
         AST_PLAIN_SUM: assert (y == WIDTH'(a + b)); // R3
      end
      if (ctl == 4'b0100) begin
         AST_INV_B_NAND_OFF: assert (y == WIDTH'(a + ~b)); // R2
      end
      if (ctl == 4'b1010) begin
         AST_INV_A_NAND: assert (y == ~(~a & b)); // R1
      end
      if (ctl == 4'b1001) begin
         AST_SUB_CODE: assert (y == WIDTH'(a - b)); // R10
      end
      if (ctl == 4'b0011) begin
         AST_AND_CODE: assert (y == (a & b)); // R5
      end
      if (ctl == 4'b1110) begin
         AST_OR_CODE: assert (y == (a | b)); // R4
      end
      AST_NEG_IS_MSB: assert (neg == y[WIDTH-1]); // R6
      AST_ZERO_FLAG: assert (zero == (y == '0)); // R7
      AST_FLAGS_EXCL: assert (!(zero && neg)); // R7
   end

endmodule

// File: tb/inv_alu_test.sv
module inv_alu_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   logic [3:0]  a4, b4, c4;
   logic [15:0] a16, b16;
   logic [3:0]  c16;
   logic [3:0]  y4;
   logic [15:0] y16;
   logic        n4, z4, n16, z16;

   inv_alu #(.WIDTH(4), .RIPPLE(1'b1)) uut (
      .a(a4), .b(b4), .ctl(c4), .y(y4), .neg(n4), .zero(z4)
   );

   inv_alu #(.WIDTH(16), .RIPPLE(1'b0)) uut16 (
      .a(a16), .b(b16), .ctl(c16), .y(y16), .neg(n16), .zero(z16)
   );

   typedef struct {
      logic [3:0]  c4;
      logic [3:0]  a4, b4, e4;
      logic        en4, ez4;
      logic [3:0]  c16;
      logic [15:0] a16, b16, e16;
      logic        en16, ez16;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1234_5678;

   // Requirement model: optional inversions around sum/NAND, width-masked
   function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                         input logic [3:0] c, input int w);
      logic [15:0] aa, bb, r, mask;
      mask = (w == 16) ? 16'hFFFF : 16'((32'd1 << w) - 1);
      aa = c[3] ? ~a : a;                 // R1
      bb = c[2] ? ~b : b;                 // R2
      r  = c[1] ? ~(aa & bb) : aa + bb;   // R3 R4
      if (c[0]) r = ~r;                   // R5
      return r & mask;
   endfunction

   function automatic logic [31:0] rnd(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] ca, input logic [3:0] xa, input logic [3:0] xb,
                        input logic [3:0] cb, input logic [15:0] wa, input logic [15:0] wb);
      item_t it;
      @(posedge clk);
      #1;
      c4 = ca; a4 = xa; b4 = xb;
      c16 = cb; a16 = wa; b16 = wb;
      it.c4 = ca; it.a4 = xa; it.b4 = xb;
      it.e4 = model({12'h0, xa}, {12'h0, xb}, ca, 4)[3:0];
      it.en4 = it.e4[3];                  // R6
      it.ez4 = (it.e4 == 4'h0);           // R7
      it.c16 = cb; it.a16 = wa; it.b16 = wb;
      it.e16 = model(wa, wb, cb, 16);
      it.en16 = it.e16[15];
      it.ez16 = (it.e16 == 16'h0);
      sb.push_back(it);
   endtask

   // Monitor: samples half a cycle after the drive, same cycle (R8)
   always @(negedge clk) begin
      if (!rst && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(y4 === it.e4, "R1 R2 R3 R4 R5 R8 result w4", {12'h0, y4}, {12'h0, it.e4});
         check(n4 === it.en4, "R6 neg w4", {15'h0, n4}, {15'h0, it.en4});
         check(z4 === it.ez4, "R7 zero w4", {15'h0, z4}, {15'h0, it.ez4});
         check(y16 === it.e16, "R9 result w16", y16, it.e16);
         check(n16 === it.en16, "R9 R6 neg w16", {15'h0, n16}, {15'h0, it.en16});
         check(z16 === it.ez16, "R9 R7 zero w16", {15'h0, z16}, {15'h0, it.ez16});
         if (it.c4 == 4'b1001)
            check(y4 === 4'(it.a4 - it.b4), "R10 subtract", {12'h0, y4},
                  {12'h0, 4'(it.a4 - it.b4)});
         if (it.c4 == 4'b0011)
            check(y4 === (it.a4 & it.b4), "R10 and", {12'h0, y4}, {12'h0, it.a4 & it.b4});
         if (it.c4 == 4'b1110)
            check(y4 === (it.a4 | it.b4), "R10 or", {12'h0, y4}, {12'h0, it.a4 | it.b4});
         if (it.c16 == 4'b1001)
            check(y16 === it.a16 - it.b16, "R10 R9 subtract w16", y16, it.a16 - it.b16);
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      c4 = '0; a4 = '0; b4 = '0; c16 = '0; a16 = '0; b16 = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-state pattern: all-zero inputs give zero result, zero flag set
      drive(4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 16'h0);
      // exhaustive width-4 sweep, random width-16 alongside (R1..R5, R9)
      for (int c = 0; c < 16; c++) begin
         for (int x = 0; x < 16; x++) begin
            for (int z = 0; z < 16; z++) begin
               seed = rnd(seed);
               drive(4'(c), 4'(x), 4'(z), 4'(c), seed[31:16], seed[15:0]);
            end
         end
      end
      // width-16 corners: carry drop (R3), MSB flag, zero result
      for (int c = 0; c < 16; c++) begin
         drive(4'(c), 4'hF, 4'h1, 4'(c), 16'hFFFF, 16'h0001);
         drive(4'(c), 4'h8, 4'h8, 4'(c), 16'h8000, 16'h8000);
         drive(4'(c), 4'h7, 4'h1, 4'(c), 16'h7FFF, 16'h0001);
         drive(4'(c), 4'h0, 4'h0, 4'(c), 16'h0000, 16'h0000);
      end
      // R8: a large swing right after another must not leave a trace
      drive(4'b0000, 4'hF, 4'hF, 4'b0000, 16'hFFFF, 16'hFFFF);
      drive(4'b0000, 4'h0, 4'h0, 4'b0000, 16'h0000, 16'h0000);
      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);
      finish_run();
   end

endmodule